// File: doc/BRIEF.md
# Commutation-Gated Output Control Preload

This block keeps the output-stage control of a four-channel PWM timer. Each channel has three controls: a main output enable, a complementary output enable and a 4-bit output compare mode. Software writes these controls one channel at a time. If preloading is off, a write reaches the output stage straight away. If preloading is on, the write is held in a per-channel buffer. Every channel then takes its new controls together, at a commutation event. This lets the drive pattern of a multi-phase bridge change in one clock edge.

A commutation event can come from a software strobe. It can also come from a rising edge on the timer trigger input, but only if the update-source select allows this. The block marks each commutation with a one-cycle pulse, which other logic can use to set a status flag. Write, strobe and trigger are plain level or strobe control pins. Nothing flows as a stream, so no valid/ready handshake and no back-pressure are involved.

Top module: `ocp_preload_top`

## Requirements
- R1: After reset, every active output enable, complementary enable and mode field is 0, and `com_pulse` is 0. Every buffer is also 0, so a commutation with no writes after reset leaves all active outputs at 0.
- R2: With `preload_en`=0, a write (`wr_en`=1) to channel `wr_ch` sets that channel's active controls to the written values at the clock edge that samples the write. Other channels keep their values. In the output vectors, channel n uses bit n of `act_oe` and `act_oen`, and bits 4n+3..4n of `act_mode`.
- R3: With `preload_en`=1, a write changes no active output until a commutation event occurs.
- R4: At a commutation event, every channel's active controls take the contents of its buffer at that same edge. `com_pulse` is high for the one cycle after each clock cycle that held an event.
- R5: With `com_sel`=0, a rising edge on `trig_in` causes no commutation event.
- R6: With `com_sel`=1, `trig_in` sampled high after being sampled low on the previous clock gives one commutation event. Holding `trig_in` high gives no further events. A rising edge is found by comparing with a copy of `trig_in` registered one clock earlier, which is 0 after reset.
- R7: `com_sw`=1 causes a commutation event whatever the value of `com_sel`.
- R8: If a preloaded write and a commutation event fall in the same cycle, the value already in the buffer is transferred to the active controls. The new value stays in the buffer and reaches the outputs at the next commutation.
- R9: A write made with `preload_en`=0 also loads the buffer, so a later commutation leaves that channel's active controls unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| preload_en | input | 1 | 1: writes are buffered until a commutation |
| com_sel | input | 1 | 1: a rising edge on trig_in also commutes |
| com_sw | input | 1 | Software commutation strobe |
| trig_in | input | 1 | Timer trigger input |
| wr_en | input | 1 | Control write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_oe | input | 1 | Main output enable to write |
| wr_oen | input | 1 | Complementary output enable to write |
| wr_mode | input | 4 | Output compare mode to write |
| act_oe | output | 4 | Active main enables, bit n for channel n |
| act_oen | output | 4 | Active complementary enables, bit n for channel n |
| act_mode | output | 16 | Active modes, bits 4n+3..4n for channel n |
| com_pulse | output | 1 | One-cycle pulse marking a commutation |

## Verification
Every result is due one clock edge after the stimulus that causes it. A direct write, a commutation transfer and `com_pulse` all appear after the rising edge that samples the strobe, the write or the trigger level. An edge on `trig_in` is judged against its level at the clock before. The bench drives inputs on the falling edge and checks outputs on the next falling edge, halfway between the edge that should produce a result and the one that would remove it. The no-effect cases (writes held in the buffer, a trigger that is ignored or held high) are checked over the same window, so a late or spurious update would be caught.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  // Layout of one channel's control word inside the block.
  localparam int unsigned CW_OE   = 0;
  localparam int unsigned CW_OEN  = 1;
  localparam int unsigned CW_MODE = 2;

  function automatic int unsigned ctrl_width(input int unsigned mode_w);
    return mode_w + 2;
  endfunction
endpackage

// File: rtl/ocp_trig_edge.sv
module ocp_trig_edge (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic trig_rise
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig_in;
  end

  assign trig_rise = trig_in & ~trig_q;

  AST_RISE_ONCE: assert property (@(posedge clk) disable iff (rst)
    trig_rise |=> !trig_rise) // R6
    else $error("trigger rise seen on two consecutive cycles");
endmodule

// File: rtl/ocp_com_gen.sv
module ocp_com_gen (
  input  logic clk,
  input  logic rst,
  input  logic com_sw,
  input  logic com_sel,
  input  logic trig_rise,
  output logic com_evt,
  output logic com_pulse
);
  assign com_evt = com_sw | (com_sel & trig_rise);

  always_ff @(posedge clk) begin
    if (rst) com_pulse <= 1'b0;
    else     com_pulse <= com_evt;
  end

  AST_SW_COMMUTES: assert property (@(posedge clk) disable iff (rst)
    com_sw |=> com_pulse) // R7
    else $error("software strobe gave no commutation pulse");

  AST_SEL_BLOCKS_TRIG: assert property (@(posedge clk) disable iff (rst)
    (!com_sw && !com_sel) |=> !com_pulse) // R5
    else $error("commutation without software strobe while trigger disabled");
endmodule

// File: rtl/ocp_chan_slot.sv
module ocp_chan_slot #(
  parameter int unsigned CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              preload_en,
  input  logic              com,
  output logic [CTRL_W-1:0] active
);
  logic [CTRL_W-1:0] buf_q;
  logic              direct;

  assign direct = wr_hit & ~preload_en;

  // The buffer always takes a write; a commutation moves the old buffer value.
  always_ff @(posedge clk) begin
    if (rst)         buf_q <= '0;
    else if (wr_hit) buf_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         active <= '0;
    else if (direct) active <= wr_data;
    else if (com)    active <= buf_q;
  end

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
    direct |=> (active == $past(wr_data))) // R2
    else $error("direct write did not reach active controls");

  AST_HOLD_UNTIL_COM: assert property (@(posedge clk) disable iff (rst)
    (!direct && !com) |=> $stable(active)) // R3
    else $error("active controls moved without a commutation");

  AST_COM_TRANSFER: assert property (@(posedge clk) disable iff (rst)
    (com && !direct) |=> (active == $past(buf_q))) // R4
    else $error("commutation did not transfer buffer");
endmodule

// File: rtl/ocp_preload_top.sv
module ocp_preload_top #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned MODE_W = 4,
  localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned CTRL_W = ocp_pkg::ctrl_width(MODE_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  preload_en,
  input  logic                  com_sel,
  input  logic                  com_sw,
  input  logic                  trig_in,
  input  logic                  wr_en,
  input  logic [CH_W-1:0]       wr_ch,
  input  logic                  wr_oe,
  input  logic                  wr_oen,
  input  logic [MODE_W-1:0]     wr_mode,
  output logic [NCH-1:0]        act_oe,
  output logic [NCH-1:0]        act_oen,
  output logic [NCH*MODE_W-1:0] act_mode,
  output logic                  com_pulse
);
  logic              trig_rise;
  logic              com_evt;
  logic [CTRL_W-1:0] wr_word;

  always_comb begin
    wr_word = '0;
    wr_word[ocp_pkg::CW_OE]  = wr_oe;
    wr_word[ocp_pkg::CW_OEN] = wr_oen;
    wr_word[ocp_pkg::CW_MODE +: MODE_W] = wr_mode;
  end

  ocp_trig_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .trig_in   (trig_in),
    .trig_rise (trig_rise)
  );

  ocp_com_gen u_com (
    .clk       (clk),
    .rst       (rst),
    .com_sw    (com_sw),
    .com_sel   (com_sel),
    .trig_rise (trig_rise),
    .com_evt   (com_evt),
    .com_pulse (com_pulse)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic              hit;
    logic [CTRL_W-1:0] act_w;

    assign hit = wr_en && (wr_ch == CH_W'(g));

    ocp_chan_slot #(.CTRL_W(CTRL_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .wr_hit     (hit),
      .wr_data    (wr_word),
      .preload_en (preload_en),
      .com        (com_evt),
      .active     (act_w)
    );

    assign act_oe[g]                    = act_w[ocp_pkg::CW_OE];
    assign act_oen[g]                   = act_w[ocp_pkg::CW_OEN];
    assign act_mode[g*MODE_W +: MODE_W] = act_w[ocp_pkg::CW_MODE +: MODE_W];
  end

  AST_TRIG_COMMUTES: assert property (@(posedge clk) disable iff (rst)
    (com_sel && trig_in && !$past(trig_in)) |=> com_pulse) // R6
    else $error("enabled trigger edge gave no commutation");
endmodule

// File: tb/ocp_preload_top_test.sv
module ocp_preload_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        preload_en, com_sel, com_sw, trig_in, wr_en;
  logic [1:0]  wr_ch;
  logic        wr_oe, wr_oen;
  logic [3:0]  wr_mode;
  logic [3:0]  act_oe, act_oen;
  logic [15:0] act_mode;
  logic        com_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ocp_preload_top uut (
    .clk(clk), .rst(rst), .preload_en(preload_en), .com_sel(com_sel),
    .com_sw(com_sw), .trig_in(trig_in), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_oe(wr_oe), .wr_oen(wr_oen), .wr_mode(wr_mode), .act_oe(act_oe),
    .act_oen(act_oen), .act_mode(act_mode), .com_pulse(com_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock edge; inputs set before it, outputs valid after.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_wr(input logic [1:0] ch, input logic oe, input logic oen, input logic [3:0] m);
    wr_en = 1'b1; wr_ch = ch; wr_oe = oe; wr_oen = oen; wr_mode = m;
  endtask

  task automatic t_reset();
    chk("R1 oe", 32'(act_oe), 32'h0);
    chk("R1 oen", 32'(act_oen), 32'h0);
    chk("R1 mode", 32'(act_mode), 32'h0);
    chk("R1 pulse", 32'(com_pulse), 32'h0);
    com_sw = 1'b1; tick(); com_sw = 1'b0;
    chk("R1 empty buffer", {act_oe, act_oen, act_mode}, 32'h0);
    tick();
  endtask

  task automatic t_direct();
    preload_en = 1'b0;
    set_wr(2'd2, 1'b1, 1'b0, 4'h5); tick(); wr_en = 1'b0;
    chk("R2 oe", 32'(act_oe), 32'h4);
    chk("R2 oen", 32'(act_oen), 32'h0);
    chk("R2 mode", 32'(act_mode), 32'h0500);
    com_sw = 1'b1; com_sel = 1'b1; tick(); com_sw = 1'b0; com_sel = 1'b0;
    chk("R7 pulse", 32'(com_pulse), 32'h1);
    chk("R9 unchanged", {act_oe, act_oen, act_mode}, {4'h4, 4'h0, 16'h0500});
    tick();
  endtask

  task automatic t_preload();
    preload_en = 1'b1;
    set_wr(2'd0, 1'b1, 1'b1, 4'hA); tick();
    chk("R3 held a", {act_oe, act_oen, act_mode}, {4'h4, 4'h0, 16'h0500});
    set_wr(2'd3, 1'b0, 1'b1, 4'h7); tick(); wr_en = 1'b0;
    chk("R3 held b", {act_oe, act_oen, act_mode}, {4'h4, 4'h0, 16'h0500});
    chk("R3 no pulse", 32'(com_pulse), 32'h0);
    com_sw = 1'b1; tick(); com_sw = 1'b0;
    chk("R4 transfer", {act_oe, act_oen, act_mode}, {4'h5, 4'h9, 16'h750A});
    chk("R4 pulse", 32'(com_pulse), 32'h1);
    tick();
    chk("R4 pulse one cycle", 32'(com_pulse), 32'h0);
  endtask

  task automatic t_trig_off();
    com_sel = 1'b0;
    set_wr(2'd1, 1'b1, 1'b0, 4'h3); tick(); wr_en = 1'b0;
    trig_in = 1'b1; tick();
    chk("R5 no pulse", 32'(com_pulse), 32'h0);
    chk("R5 unchanged", {act_oe, act_oen, act_mode}, {4'h5, 4'h9, 16'h750A});
    trig_in = 1'b0; tick();
  endtask

  task automatic t_trig_on();
    com_sel = 1'b1; trig_in = 1'b0; tick();
    trig_in = 1'b1; tick();
    chk("R6 pulse", 32'(com_pulse), 32'h1);
    chk("R6 transfer", {act_oe, act_oen, act_mode}, {4'h7, 4'h9, 16'h753A});
    set_wr(2'd1, 1'b1, 1'b0, 4'h9); tick(); wr_en = 1'b0;
    chk("R6 held high no pulse", 32'(com_pulse), 32'h0);
    chk("R6 held high no transfer", 32'(act_mode), 32'h753A);
    trig_in = 1'b0; tick();
    trig_in = 1'b1; tick();
    chk("R6 second edge", 32'(act_mode), 32'h759A);
    trig_in = 1'b0; com_sel = 1'b0; tick();
  endtask

  task automatic t_collide();
    set_wr(2'd0, 1'b1, 1'b1, 4'h1); tick();
    set_wr(2'd0, 1'b1, 1'b1, 4'h2); com_sw = 1'b1; tick();
    wr_en = 1'b0; com_sw = 1'b0;
    chk("R8 old buffer moved", 32'(act_mode), 32'h7591);
    tick();
    chk("R8 new held", 32'(act_mode), 32'h7591);
    com_sw = 1'b1; tick(); com_sw = 1'b0;
    chk("R8 new on next com", 32'(act_mode), 32'h7592);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; preload_en = 1'b0; com_sel = 1'b0; com_sw = 1'b0;
    trig_in = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_oe = 1'b0; wr_oen = 1'b0; wr_mode = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_preload();
    t_trig_off();
    t_trig_on();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule